// File: doc/BRIEF.md
# UART Register Access Slave Engine

This block serves register reads and writes that a host issues over a half-duplex UART control link. A bit-level receiver in front of it delivers whole bytes, a per-byte parity flag and a line-activity indication. The engine assembles these into packets, decides whether each packet is addressed to this device, and drives a byte-wide register-file port and a transmit byte stream. Each packet consists of a sync byte, then an address byte whose top seven bits select the device and whose bit 0 selects the direction, then a register address, then a byte count, and on writes the data bytes themselves.

Packets are framed by timing, not by delimiters. A bit-time strobe drives an idle timer: the line must stay quiet for a minimum time before a sync is honoured, and a packet is abandoned when the gap between two of its bytes grows too long. Write data is held in a staging buffer and reaches the registers only after the transmitter reports that the acknowledge byte has left the wire. A host can therefore confirm a write before it takes effect, even when that write changes the link itself.

Top module: `ucl_reg_slave`

## Requirements
- R1: After reset and after any received byte, a byte equal to 0x79 without a parity error starts a packet only if at least IDLE_MIN (16) bit-time strobes were counted with the line idle before it. Any other byte seen while waiting for a packet is ignored.
- R2: The byte after sync is the address byte. Its bits [7:1] must equal dev_addr, and bit 0 set to 1 means read. On a mismatch the packet is dropped: no byte is transmitted and no register is written.
- R3: On a write, the register address and a count N follow, then N data bytes. After these the engine transmits the single byte 0xC3. N = 0 yields the acknowledge alone. A write with N greater than MAX_BURST (8) is dropped without acknowledge.
- R4: Staged write data reaches the register port only after tx_done reports the end of the 0xC3 byte. The writes then follow one per cycle in order, with tx_valid low.
- R5: On a read, the engine transmits 0xC3 and then N bytes taken from the register port. N may be any value from 0 to 255.
- R6: Within one transfer the register address increments by one per byte and wraps from 0xFF to 0x00.
- R7: If more than GAP_LIMIT (4) idle bit-time strobes pass between two bytes of a packet before the transfer is complete, the packet is aborted with no acknowledge and no writes.
- R8: A parity error on any address, register, count or data byte aborts the packet with no acknowledge and no writes.
- R9: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per UART bit time |
| rx_active | input | 1 | Receiver is inside a character frame |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error flag for the byte in rx_data |
| dev_addr | input | 7 | Programmable device address |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter accepts tx_data this cycle |
| tx_done | input | 1 | Strobe: the last accepted byte finished on the line |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 8 | Register address for reads and writes |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for reg_addr, same cycle |

## Verification
Random packets vary direction, register address, count, address match, injected parity faults and late bytes. A reference register array predicts both the transmitted bytes and the final register contents, so a lost acknowledge, a wrong read byte or a stray write each show up as a separate mismatch. Directed packets cover the cases that random traffic rarely reaches. A sync sent after too short a quiet period tells the idle rule apart from plain sync matching, and a burst starting at 0xFE tells address wrap apart from saturation. A zero-count write and an oversized write bracket the staging depth. A monitor flags any register write seen before the acknowledge byte finished, which separates commit-after-acknowledge from commit-on-receive.

// File: rtl/ucl_pkg.sv
package ucl_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_REG,
      ST_CNT,
      ST_DATA,
      ST_ACK,
      ST_WAIT,
      ST_COMMIT,
      ST_RDATA
   } ucl_state_e;
endpackage

// File: rtl/ucl_gap_timer.sv
module ucl_gap_timer #(
   parameter int SAT = 16,
   localparam int W  = $clog2(SAT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_tick,
   input  logic         rx_active,
   input  logic         rx_valid,
   output logic [W-1:0] gap_cnt
);
   // counts idle bit times since the end of the last byte, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_cnt <= '0;
      else if (rx_valid)
         gap_cnt <= '0;
      else if (bit_tick && !rx_active && gap_cnt != W'(SAT))
         gap_cnt <= gap_cnt + 1'b1;
   end
endmodule

// File: rtl/ucl_stage_buf.sv
module ucl_stage_buf #(
   parameter int DEPTH       = 8,
   parameter bit RESET_STAGE = 1'b0,
   localparam int IW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [7:0]    wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [7:0]    rd_data
);
   logic [7:0] slot [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      if (RESET_STAGE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot[g] <= '0;
            else if (wr_en && wr_idx == IW'(g))
               slot[g] <= wr_data;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IW'(g))
               slot[g] <= wr_data;
         end
      end
   end

   assign rd_data = slot[rd_idx];
endmodule

// File: rtl/ucl_reg_slave.sv
module ucl_reg_slave #(
   parameter int       MAX_BURST   = 8,
   parameter int       GAP_LIMIT   = 4,
   parameter int       IDLE_MIN    = 16,
   parameter logic [7:0] SYNC_BYTE = 8'h79,
   parameter logic [7:0] ACK_BYTE  = 8'hC3,
   parameter bit       RESET_STAGE = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_tick,
   input  logic       rx_active,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   input  logic       rx_perr,
   input  logic [6:0] dev_addr,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   input  logic       tx_ready,
   input  logic       tx_done,
   output logic       reg_wr,
   output logic [7:0] reg_addr,
   output logic [7:0] reg_wdata,
   input  logic [7:0] reg_rdata
);
   import ucl_pkg::*;

   localparam int IW = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;
   localparam int GW = $clog2(IDLE_MIN + 1);

   if (MAX_BURST < 1 || MAX_BURST > 255) begin : g_bad_burst
      $error("MAX_BURST must lie in 1..255");
   end
   if (GAP_LIMIT < 1 || GAP_LIMIT >= IDLE_MIN) begin : g_bad_gap
      $error("GAP_LIMIT must be at least 1 and below IDLE_MIN");
   end

   ucl_state_e  state;
   logic        is_read;
   logic [7:0]  base;
   logic [7:0]  cnt;
   logic [7:0]  idx;
   logic [GW-1:0] gap_cnt;
   logic [7:0]  stage_q;
   logic        stage_we;
   logic        last;
   logic        in_header;
   logic        late;
   logic        byte_ok;

   ucl_gap_timer #(.SAT(IDLE_MIN)) u_gap (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .rx_active (rx_active),
      .rx_valid  (rx_valid),
      .gap_cnt   (gap_cnt)
   );

   ucl_stage_buf #(.DEPTH(MAX_BURST), .RESET_STAGE(RESET_STAGE)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (stage_we),
      .wr_idx  (idx[IW-1:0]),
      .wr_data (rx_data),
      .rd_idx  (idx[IW-1:0]),
      .rd_data (stage_q)
   );

   assign last      = (idx == cnt - 8'd1);
   assign in_header = (state == ST_ADDR) || (state == ST_REG) ||
                      (state == ST_CNT)  || (state == ST_DATA);
   assign late      = gap_cnt > GW'(GAP_LIMIT);
   assign byte_ok   = rx_valid && !rx_perr;
   assign stage_we  = (state == ST_DATA) && byte_ok && !late;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         is_read <= 1'b0;
         base    <= '0;
         cnt     <= '0;
         idx     <= '0;
      end else if (in_header && (late || (rx_valid && rx_perr))) begin
         state <= ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE:
               if (byte_ok && rx_data == SYNC_BYTE && gap_cnt >= GW'(IDLE_MIN))
                  state <= ST_ADDR;
            ST_ADDR:
               if (rx_valid) begin
                  is_read <= rx_data[0];
                  state   <= (rx_data[7:1] == dev_addr) ? ST_REG : ST_IDLE;
               end
            ST_REG:
               if (rx_valid) begin
                  base  <= rx_data;
                  state <= ST_CNT;
               end
            ST_CNT:
               if (rx_valid) begin
                  cnt <= rx_data;
                  idx <= '0;
                  if (is_read || rx_data == 8'd0)
                     state <= ST_ACK;
                  else if (rx_data > 8'(MAX_BURST))
                     state <= ST_IDLE;
                  else
                     state <= ST_DATA;
               end
            ST_DATA:
               if (rx_valid) begin
                  idx <= idx + 8'd1;
                  if (last)
                     state <= ST_ACK;
               end
            ST_ACK:
               if (tx_ready) begin
                  idx <= '0;
                  if (!is_read)
                     state <= ST_WAIT;
                  else
                     state <= (cnt == 8'd0) ? ST_IDLE : ST_RDATA;
               end
            ST_WAIT:
               if (tx_done)
                  state <= (cnt == 8'd0) ? ST_IDLE : ST_COMMIT;
            ST_COMMIT: begin
               idx <= idx + 8'd1;
               if (last)
                  state <= ST_IDLE;
            end
            ST_RDATA:
               if (tx_ready) begin
                  idx <= idx + 8'd1;
                  if (last)
                     state <= ST_IDLE;
               end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      tx_valid  = 1'b0;
      tx_data   = ACK_BYTE;
      reg_wr    = 1'b0;
      reg_addr  = base + idx;
      reg_wdata = stage_q;
      if (state == ST_ACK) begin
         tx_valid = 1'b1;
      end else if (state == ST_RDATA) begin
         tx_valid = 1'b1;
         tx_data  = reg_rdata;
      end else if (state == ST_COMMIT) begin
         reg_wr = 1'b1;
      end
   end
endmodule

// File: rtl/ucl_reg_slave_chk.sv
module ucl_reg_slave_chk #(
   parameter logic [7:0] ACK_BYTE = 8'hC3
) (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_valid,
   input logic [7:0] tx_data,
   input logic       tx_ready,
   input logic       tx_done,
   input logic       reg_wr,
   input logic [7:0] reg_addr
);
   logic last_was_ack;
   logic ack_finished;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_was_ack <= 1'b0;
         ack_finished <= 1'b0;
      end else if (tx_valid && tx_ready) begin
         last_was_ack <= (tx_data == ACK_BYTE);
         ack_finished <= 1'b0;
      end else if (tx_done && last_was_ack) begin
         ack_finished <= 1'b1;
      end
   end

   // R4
   commit_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> ack_finished);

   // R4
   commit_tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> !tx_valid);

   // R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && $past(reg_wr)) |-> (reg_addr == $past(reg_addr) + 8'd1));

   // R9
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind ucl_reg_slave ucl_reg_slave_chk #(.ACK_BYTE(ACK_BYTE)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_valid (tx_valid),
   .tx_data  (tx_data),
   .tx_ready (tx_ready),
   .tx_done  (tx_done),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr)
);

// File: tb/sim_ucl_reg_slave.sv
`timescale 1ns/1ps
module sim_ucl_reg_slave;
   localparam int          MAXB  = 8;
   localparam logic [6:0]  DEV   = 7'h2A;
   localparam int          BT    = 4;
   localparam int          TXLEN = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       rx_active = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_perr = 1'b0;
   logic       tx_valid;
   logic [7:0] tx_data;
   logic       tx_ready;
   logic       tx_done;
   logic       reg_wr;
   logic [7:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ucl_reg_slave #(.MAX_BURST(MAXB)) u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_active(rx_active),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
      .dev_addr(DEV), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .tx_done(tx_done), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   // bit-time strobe
   int tick_div = 0;
   always @(posedge clk) begin
      tick_div <= (tick_div == BT - 1) ? 0 : tick_div + 1;
      bit_tick <= (tick_div == BT - 1);
   end

   // transmitter model
   int busy = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_ready <= 1'b1;
         tx_done  <= 1'b0;
         busy     <= 0;
      end else begin
         tx_done <= 1'b0;
         if (busy != 0) begin
            busy <= busy - 1;
            if (busy == 1) begin
               tx_done  <= 1'b1;
               tx_ready <= 1'b1;
            end
         end else if (tx_valid && tx_ready) begin
            tx_ready <= 1'b0;
            busy     <= TXLEN;
         end
      end
   end

   // register file and reference copy
   logic [7:0] regs [256];
   logic [7:0] model [256];
   assign reg_rdata = regs[reg_addr];
   always @(posedge clk) if (reg_wr) regs[reg_addr] <= reg_wdata;

   // monitors, sampled on the falling edge
   logic [7:0] cap [512];
   int   cap_n = 0;
   int   wr_n = 0;
   logic last_ack = 1'b0;
   logic ack_seen = 1'b0;
   logic prev_stall = 1'b0;
   logic [7:0] prev_data = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall) begin
            checks++;
            if (!tx_valid || tx_data != prev_data) begin
               errors++;
               $display("FAIL R9 hold: valid=%0b data=%02h expected valid=1 data=%02h",
                        tx_valid, tx_data, prev_data);
            end
         end
         prev_stall = tx_valid && !tx_ready;
         prev_data  = tx_data;
         if (reg_wr) begin
            wr_n++;
            checks++;
            if (!ack_seen || tx_valid) begin
               errors++;
               $display("FAIL R4 write before ack done: ack_done=%0b tx_valid=%0b expected 1/0",
                        ack_seen, tx_valid);
            end
         end
         if (tx_valid && tx_ready) begin
            if (cap_n < 512) cap[cap_n] = tx_data;
            cap_n++;
            last_ack = (tx_data == 8'hC3);
            ack_seen = 1'b0;
         end
         if (tx_done && last_ack) ack_seen = 1'b1;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      repeat (n * BT) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic perr);
      rx_active = 1'b1;
      repeat (10) @(negedge clk);
      rx_active = 1'b0;
      rx_valid  = 1'b1;
      rx_data   = b;
      rx_perr   = perr;
      @(negedge clk);
      rx_valid  = 1'b0;
      rx_perr   = 1'b0;
   endtask

   logic [7:0] pdata [256];

   // one packet: perr_at / late_at index the byte list (sync = 0), -1 for none
   task automatic packet(input string req, input logic [7:0] abyte, input logic [7:0] rg,
                         input logic [7:0] n, input int perr_at, input int late_at,
                         input int pre_idle);
      int   nbytes;
      logic rd;
      logic accept;
      logic [7:0] exp_tx [260];
      int   exp_n;
      int   exp_w;
      int   mism;
      rd = abyte[0];
      nbytes = rd ? 4 : 4 + int'(n);
      accept = (pre_idle >= 16) && (abyte[7:1] == DEV) && (perr_at < 0) &&
               (late_at < 0) && (rd || n <= MAXB);
      exp_n = 0;
      exp_w = 0;
      if (accept) begin
         exp_tx[0] = 8'hC3;
         exp_n = 1;
         if (rd) begin
            for (int i = 0; i < int'(n); i++) exp_tx[1 + i] = model[8'(rg + 8'(i))];
            exp_n = 1 + int'(n);
         end else begin
            for (int i = 0; i < int'(n); i++) model[8'(rg + 8'(i))] = pdata[i];
            exp_w = int'(n);
         end
      end
      cap_n = 0;
      wr_n  = 0;
      send_byte(8'hFF, 1'b0);
      wait_ticks(pre_idle);
      for (int k = 0; k < nbytes; k++) begin
         logic [7:0] b;
         if (k == 0) b = 8'h79;
         else if (k == 1) b = abyte;
         else if (k == 2) b = rg;
         else if (k == 3) b = n;
         else b = pdata[k - 4];
         if (k > 0) wait_ticks((k == late_at) ? 8 : 1);
         send_byte(b, k == perr_at);
      end
      repeat (600) @(negedge clk);
      check(req, "tx byte count", cap_n, exp_n);
      for (int i = 0; i < exp_n && i < cap_n; i++)
         check(req, $sformatf("tx byte %0d", i), int'(cap[i]), int'(exp_tx[i]));
      check(req, "write count", wr_n, exp_w);
      mism = 0;
      for (int a = 0; a < 256; a++) if (regs[a] !== model[a]) mism++;
      check(req, "register mismatches", mism, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      for (int a = 0; a < 256; a++) begin
         regs[a]  = 8'(a * 7) ^ 8'h5A;
         model[a] = 8'(a * 7) ^ 8'h5A;
      end
      repeat (4) @(negedge clk);
      check("R1", "reset tx_valid", int'(tx_valid), 0);
      check("R1", "reset reg_wr", int'(reg_wr), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // directed cases
      pdata[0] = 8'h11; pdata[1] = 8'h22; pdata[2] = 8'h33;
      packet("R3", {DEV, 1'b0}, 8'h10, 8'd3, -1, -1, 20);
      packet("R5", {DEV, 1'b1}, 8'h10, 8'd3, -1, -1, 20);
      pdata[0] = 8'hA0; pdata[1] = 8'hA1; pdata[2] = 8'hA2; pdata[3] = 8'hA3;
      packet("R6", {DEV, 1'b0}, 8'hFE, 8'd4, -1, -1, 20);
      packet("R6", {DEV, 1'b1}, 8'hFE, 8'd4, -1, -1, 20);
      packet("R2", {DEV ^ 7'h01, 1'b0}, 8'h40, 8'd2, -1, -1, 20);
      packet("R2", {DEV ^ 7'h40, 1'b1}, 8'h40, 8'd2, -1, -1, 20);
      packet("R8", {DEV, 1'b0}, 8'h50, 8'd3, 5, -1, 20);
      packet("R8", {DEV, 1'b1}, 8'h50, 8'd3, 2, -1, 20);
      packet("R7", {DEV, 1'b0}, 8'h60, 8'd3, -1, 3, 20);
      packet("R7", {DEV, 1'b0}, 8'h60, 8'd3, -1, 6, 20);
      packet("R1", {DEV, 1'b0}, 8'h70, 8'd2, -1, -1, 10);
      packet("R3", {DEV, 1'b0}, 8'h80, 8'd0, -1, -1, 20);
      for (int i = 0; i < 9; i++) pdata[i] = 8'(8'hC0 + i);
      packet("R3", {DEV, 1'b0}, 8'h80, 8'd9, -1, -1, 20);
      packet("R5", {DEV, 1'b1}, 8'hF8, 8'd12, -1, -1, 20);
      packet("R5", {DEV, 1'b1}, 8'h20, 8'd0, -1, -1, 20);

      // constrained random traffic
      for (int t = 0; t < 40; t++) begin
         logic       rd;
         logic [6:0] da;
         logic [7:0] n;
         int         pe;
         int         lt;
         rd = 1'($urandom % 2);
         da = ($urandom % 100 < 85) ? DEV : 7'($urandom);
         n  = rd ? 8'($urandom % 13) : 8'($urandom % (MAXB + 1));
         for (int i = 0; i < 256; i++) pdata[i] = 8'($urandom);
         pe = ($urandom % 100 < 10) ? 1 + int'($urandom % 3) : -1;
         lt = ($urandom % 100 < 10) ? 1 + int'($urandom % 3) : -1;
         packet(rd ? "R5" : "R3", {da, rd}, 8'($urandom), n, pe, lt, 20);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule